// File: doc/BRIEF.md
# Phase Comparator with Lock Indication and One-Shot Fast-Lock Control

This block sits between the reference divider and the feedback divider of a frequency synthesizer loop. It samples the divided reference pulse and the divided oscillator pulse on the reference clock and runs a two-register phase-frequency comparator on their rising edges. The comparator produces three digital controls for the charge pump: pump up, pump down, and a high-impedance enable for the idle state. The pump is driven for as many clock cycles as the two edges are apart.

A lock flag drops low while the pump is driven, so software or a pin can watch the error width. A control input can hold the flag inactive to keep its switching noise off the board. After each reset, the first phase error opens a fast-acquisition window a fixed number of reference clocks wide. During that window the fast-lock pin is driven low, and an auxiliary pump stage can be enabled. The window never opens again until the next reset. A test pin can route either raw divider pulse onto the lock pin and can force the fast-lock pin high.

Top module: `pfd_lock_top`

## Requirements
- R1: A rising edge on `ref_pulse` sets pump-up and a rising edge on `fb_pulse` sets pump-down, each visible on the outputs in the cycle after the edge is sampled. A lone error lasts exactly as many cycles as the two edges are apart.
- R2: When both pump registers would be set, both clear on that edge. Coincident edges produce no pump pulse, and `pump_up` and `pump_dn` are never high together.
- R3: `pump_hiz` is 1 exactly when neither `pump_up` nor `pump_dn` is 1.
- R4: With `test_mode`=0 and `lock_show`=1, `lock_out` is 0 while either pump output is 1 and 1 otherwise. With `lock_show`=0, `lock_out` stays 1 regardless of phase error.
- R5: The first non-coincident divider edge after reset starts a window of `WIN_CLKS` (default 4) cycles. The window starts in the same cycle as the resulting pump pulse. During the window `fl_oe`=1 and `fl_lvl`=0; outside it, `fl_oe`=0 and `fl_lvl`=0.
- R6: The window opens at most once per reset. Later phase errors never reopen it, and only a reset re-arms it.
- R7: `aux_pump_en` equals 1 exactly when `boost_en`=1 and the fast-lock window is open.
- R8: With `test_mode`=1 and `test_sel`=0, `lock_out` follows the `fb_pulse` input without a register, and the fast-lock pin is forced driven high (`fl_oe`=1, `fl_lvl`=1).
- R9: With `test_mode`=1 and `test_sel`=1, `lock_out` follows the `ref_pulse` input without a register, and the fast-lock outputs behave as in R5.
- R10: After reset the pump is idle (`pump_hiz`=1), `lock_out`=1, `fl_oe`=0 and `aux_pump_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Active-low power-on reset |
| ref_pulse | input | 1 | Divided reference pulse |
| fb_pulse | input | 1 | Divided oscillator (feedback) pulse |
| lock_show | input | 1 | 1 = lock flag reflects phase error, 0 = held inactive |
| test_sel | input | 1 | Test selection bit from the control register |
| test_mode | input | 1 | Test pin |
| boost_en | input | 1 | Enables the auxiliary pump during the fast-lock window |
| pump_up | output | 1 | Charge pump drive high |
| pump_dn | output | 1 | Charge pump drive low |
| pump_hiz | output | 1 | Charge pump output released |
| lock_out | output | 1 | Lock flag, low during phase error |
| fl_oe | output | 1 | Fast-lock pin output enable |
| fl_lvl | output | 1 | Fast-lock pin level when enabled |
| aux_pump_en | output | 1 | Auxiliary charge pump enable |

## Verification
A stuck pump register shows on the cycle after the next divider edge, as a pump pulse of the wrong length or one that is missing or never ends. The lock flag and the release enable track that error in the same cycle. A wrong armed flag or window counter shows at the fast-lock and auxiliary enables. It appears either as a window of the wrong length after the first error, or as a second window on a later error. After a mid-run reset, it also appears as a window that fails to reopen. Test-mode errors appear at once on the lock pin, because the selected divider input passes through without a register.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_st_t;

endpackage

// File: rtl/edge_rise.sv
module edge_rise #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_in,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = sig_in[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_lock_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fr_rise,
    input  logic     fn_rise,
    output pump_st_t pump
);
    pump_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.up = st_q.up | fr_rise;
        st_d.dn = st_q.dn | fn_rise;
        if (st_d.up && st_d.dn) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pump = st_q;

    // R2
    pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.up && st_q.dn));
    // R1
    up_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_rise && !fn_rise && !st_q.dn) |=> st_q.up);
    // R2
    coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_rise && fn_rise && !st_q.up && !st_q.dn) |=> (!st_q.up && !st_q.dn));
endmodule

// File: rtl/fastlock_oneshot.sv
module fastlock_oneshot #(
    parameter int WIN_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic window
);
    localparam int CNT_W = $clog2(WIN_CLKS + 1);
    localparam logic [CNT_W-1:0] WIN_LD = CNT_W'(WIN_CLKS);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } fl_st_t;

    fl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        if (st_q.armed && trigger) begin
            st_d.armed = 1'b0;
            st_d.cnt   = WIN_LD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed <= 1'b1;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign window = (st_q.cnt != '0);

    // R6
    no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |=> !st_q.armed);
    // R5
    idle_until_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> (st_q.cnt == '0));
    // R5
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= WIN_LD);
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
    import pfd_lock_pkg::*;
#(
    parameter int WIN_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic fb_pulse,
    input  logic lock_show,
    input  logic test_sel,
    input  logic test_mode,
    input  logic boost_en,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_hiz,
    output logic lock_out,
    output logic fl_oe,
    output logic fl_lvl,
    output logic aux_pump_en
);
    logic [1:0] rises;
    pump_st_t   pump;
    logic       fl_win;

    edge_rise #(.W(2)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({fb_pulse, ref_pulse}),
        .rise   (rises)
    );

    pfd_core u_pfd (
        .clk     (clk),
        .rst_n   (rst_n),
        .fr_rise (rises[0]),
        .fn_rise (rises[1]),
        .pump    (pump)
    );

    fastlock_oneshot #(.WIN_CLKS(WIN_CLKS)) u_fl (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (rises[0] ^ rises[1]),
        .window  (fl_win)
    );

    always_comb begin
        pump_up     = pump.up;
        pump_dn     = pump.dn;
        pump_hiz    = ~(pump.up | pump.dn);
        aux_pump_en = boost_en & fl_win;
        if (test_mode)      lock_out = test_sel ? ref_pulse : fb_pulse;
        else if (lock_show) lock_out = ~(pump.up | pump.dn);
        else                lock_out = 1'b1;
        if (test_mode && !test_sel) begin
            fl_oe  = 1'b1;
            fl_lvl = 1'b1;
        end else begin
            fl_oe  = fl_win;
            fl_lvl = 1'b0;
        end
    end

    // R7
    aux_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_pump_en |-> (fl_oe || test_mode));
endmodule

// File: tb/pfd_lock_top_test.sv
module pfd_lock_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0, fb_pulse = 1'b0;
    logic lock_show = 1'b1, test_sel = 1'b0, test_mode = 1'b0, boost_en = 1'b1;
    logic pump_up, pump_dn, pump_hiz, lock_out, fl_oe, fl_lvl, aux_pump_en;

    always #10 clk = ~clk;

    pfd_lock_top #(.WIN_CLKS(4)) uut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .lock_show(lock_show), .test_sel(test_sel), .test_mode(test_mode),
        .boost_en(boost_en), .pump_up(pump_up), .pump_dn(pump_dn),
        .pump_hiz(pump_hiz), .lock_out(lock_out), .fl_oe(fl_oe),
        .fl_lvl(fl_lvl), .aux_pump_en(aux_pump_en)
    );

    typedef struct {
        logic [6:0] vec;
        string      req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // monitor: compares one expected item per cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            logic [6:0] act;
            e = q.pop_front();
            act = {pump_up, pump_dn, pump_hiz, lock_out, fl_oe, fl_lvl, aux_pump_en};
            checks++;
            if (act !== e.vec) begin
                errors++;
                $display("FAIL %s: up,dn,hiz,ld,fl_oe,fl_lvl,aux actual %b expected %b",
                         e.req, act, e.vec);
            end
        end
    end

    // cfg = {lock_show, test_mode, test_sel, boost_en}
    task automatic cyc(input logic fr, input logic fn, input logic [3:0] cfg,
                       input logic up, input logic dn, input logic ld,
                       input logic oe, input logic lvl, input logic aux,
                       input string req);
        exp_t e;
        @(negedge clk);
        #1;
        ref_pulse = fr;
        fb_pulse  = fn;
        {lock_show, test_mode, test_sel, boost_en} = cfg;
        e.vec = {up, dn, ~(up | dn), ld, oe, lvl, aux};
        e.req = req;
        q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        ref_pulse = 1'b0;
        fb_pulse = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    localparam logic [3:0] NORM  = 4'b1001;
    localparam logic [3:0] NOLD  = 4'b0001;
    localparam logic [3:0] TST0  = 4'b1101;
    localparam logic [3:0] TST1  = 4'b1111;
    localparam logic [3:0] NOAUX = 4'b1000;

    initial begin
        do_reset();
        cyc(0,0,NORM, 0,0,1,0,0,0, "R10");
        // first error: reference leads by 3 cycles, window opens
        cyc(1,0,NORM, 1,0,0,1,0,1, "R1 R5 R7");
        cyc(0,0,NORM, 1,0,0,1,0,1, "R1 R5");
        cyc(0,0,NORM, 1,0,0,1,0,1, "R1 R3");
        cyc(0,1,NORM, 0,0,1,1,0,1, "R2 R5");
        cyc(0,0,NORM, 0,0,1,0,0,0, "R5 R7");
        // feedback leads by 2: no new window
        cyc(0,1,NORM, 0,1,0,0,0,0, "R1 R6");
        cyc(0,0,NORM, 0,1,0,0,0,0, "R4 R6");
        cyc(1,0,NORM, 0,0,1,0,0,0, "R2");
        // coincident edges
        cyc(0,0,NORM, 0,0,1,0,0,0, "R3");
        cyc(1,1,NORM, 0,0,1,0,0,0, "R2");
        cyc(0,0,NORM, 0,0,1,0,0,0, "R2");
        // lock flag held inactive
        cyc(1,0,NOLD, 1,0,1,0,0,0, "R4");
        cyc(0,1,NOLD, 0,0,1,0,0,0, "R4");
        // test mode, feedback routed
        cyc(0,0,TST0, 0,0,0,1,1,0, "R8");
        cyc(0,1,TST0, 0,1,1,1,1,0, "R8");
        cyc(1,0,TST0, 0,0,0,1,1,0, "R8");
        // test mode, reference routed
        cyc(0,0,TST1, 0,0,0,0,0,0, "R9");
        cyc(1,0,TST1, 1,0,1,0,0,0, "R9");
        cyc(0,1,TST1, 0,0,0,0,0,0, "R9");
        // reset re-arms; auxiliary pump off when boost disabled
        do_reset();
        cyc(0,0,NOAUX, 0,0,1,0,0,0, "R10");
        cyc(0,1,NOAUX, 0,1,0,1,0,0, "R6 R7");
        cyc(1,0,NOAUX, 0,0,1,1,0,0, "R5");
        cyc(0,0,NOAUX, 0,0,1,1,0,0, "R5");
        cyc(0,0,NOAUX, 0,0,1,1,0,0, "R5");
        cyc(0,0,NOAUX, 0,0,1,0,0,0, "R5");
        cyc(0,0,NOAUX, 0,0,1,0,0,0, "R5");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule